// File: doc/BRIEF.md
# Variable-Length Instruction Field Parser

This block receives instruction bytes one per cycle over a valid/ready handshake and divides each instruction into its ordered fields. These are a one- or two-byte primary opcode, an optional addressing-mode byte, an optional scale-index-base byte, an optional displacement and an optional immediate. The parser does not decode opcodes. With every byte the requester drives two attribute inputs. The parser samples them on the last opcode byte only, and they say whether an addressing-mode byte follows and how many immediate bytes close the instruction. From that point on, the presence and size of each later field are worked out from bits of the bytes already taken.

When the last byte of an instruction has been accepted, the parser presents one record. The record holds every field, a presence flag or byte count for each optional field, and the total byte count. The record stays on the output until the consumer takes it. Input is refused during that time, and the parser is ready for a new opcode in the cycle after the record is taken.

Top module: `ifp_field_parser`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: A first byte equal to 0x0F is reported as opcode byte one with out_two_byte=1, and exactly one further byte is taken as opcode byte two. Any other first byte gives out_two_byte=0 and out_op_second=0.
- R3: attr_has_modrm and attr_imm_sel are sampled only with the last opcode byte. The immediate size encodes as 0 for none, 1 for one byte, 2 for two bytes and 3 for four bytes. out_imm_len reports the size in bytes.
- R4: When an addressing-mode byte is present, out_modrm holds it as mod in bits 7:6, reg in bits 5:3 and r/m in bits 2:0. A scale-index-base byte (scale 7:6, index 5:3, base 2:0) follows only when mod is not 3 and r/m is 4. Absent bytes read as zero.
- R5: The displacement size is set by mod. With mod 1 it is 1 byte and with mod 2 it is 4 bytes. With mod 3 there is none. With mod 0 it is 4 bytes when r/m is 5, or when a scale-index-base byte is present and its base field is 5. Otherwise it is 0.
- R6: Displacement bytes are packed little-endian, with the first received byte in bits 7:0. Unused upper bytes read as zero.
- R7: The immediate comes after every displacement byte, is packed little-endian with zero upper bytes, and is the final field of the instruction.
- R8: out_length equals the number of opcode bytes plus addressing bytes plus displacement bytes plus immediate bytes.
- R9: While out_valid is 1, in_ready is 0 and the record holds steady until out_ready. After the record is accepted, out_valid drops and in_ready rises in the next cycle.
- R10: A reset in the middle of an instruction discards the partial bytes, and the next byte is parsed as a fresh opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Parser can accept a byte |
| in_byte | input | 8 | Instruction byte |
| attr_has_modrm | input | 1 | Opcode has an addressing-mode byte (sampled on last opcode byte) |
| attr_imm_sel | input | 2 | Immediate size code (sampled on last opcode byte) |
| out_valid | output | 1 | Record available |
| out_ready | input | 1 | Consumer takes the record |
| out_two_byte | output | 1 | Opcode was two bytes |
| out_op_first | output | 8 | First opcode byte |
| out_op_second | output | 8 | Second opcode byte or zero |
| out_has_modrm | output | 1 | Addressing-mode byte present |
| out_modrm | output | 8 | Addressing-mode byte |
| out_has_sib | output | 1 | Scale-index-base byte present |
| out_sib | output | 8 | Scale-index-base byte |
| out_disp_len | output | 3 | Displacement size in bytes |
| out_disp | output | 32 | Displacement value |
| out_imm_len | output | 3 | Immediate size in bytes |
| out_imm | output | 32 | Immediate value |
| out_length | output | 4 | Total instruction bytes |

## Verification
A wrong parse state shows up at the handshake first. If the parser misjudges where an instruction ends, out_valid rises one or more cycles early or late, and in_ready drops or fails to drop at the wrong point. The cycle-by-cycle model flags either case in the very cycle where the two diverge. A byte routed to the wrong field appears as a field mismatch in the record where it happens. It also shifts every later boundary, so the following records keep failing and the error cannot pass unnoticed.

// File: rtl/ifp_pkg.sv
package ifp_pkg;
  localparam int BYTE_W        = 8;
  localparam int FIELD_BYTES   = 4;
  localparam int FIELD_W       = BYTE_W * FIELD_BYTES;
  localparam int FIELD_LEN_W   = $clog2(FIELD_BYTES + 1);
  localparam int MAX_LEN       = 4 + 2 * FIELD_BYTES;
  localparam int RECORD_LEN_W  = $clog2(MAX_LEN + 1);

  typedef enum logic [2:0] {
    ST_OPCODE, ST_OP2, ST_MODRM, ST_SIB, ST_DISP, ST_IMM, ST_EMIT
  } ifp_state_e;

  function automatic logic [FIELD_LEN_W-1:0] imm_sel_bytes(input logic [1:0] sel);
    case (sel)
      2'd0:    imm_sel_bytes = '0;
      2'd1:    imm_sel_bytes = FIELD_LEN_W'(1);
      2'd2:    imm_sel_bytes = FIELD_LEN_W'(2);
      default: imm_sel_bytes = FIELD_LEN_W'(4);
    endcase
  endfunction
endpackage

// File: rtl/ifp_addr_decode.sv
module ifp_addr_decode
  import ifp_pkg::*;
(
  input  logic [BYTE_W-1:0]      modrm_byte,
  input  logic [BYTE_W-1:0]      sib_byte,
  output logic                   sib_follows,
  output logic [FIELD_LEN_W-1:0] disp_plain,
  output logic [FIELD_LEN_W-1:0] disp_with_sib
);
  logic [1:0] mode;
  logic [2:0] rm;
  assign mode = modrm_byte[7:6];
  assign rm   = modrm_byte[2:0];

  assign sib_follows = (mode != 2'b11) && (rm == 3'b100);

  always_comb begin
    disp_plain    = '0;
    disp_with_sib = '0;
    case (mode)
      2'b00: begin
        if (rm == 3'b101)            disp_plain    = FIELD_LEN_W'(4);
        if (sib_byte[2:0] == 3'b101) disp_with_sib = FIELD_LEN_W'(4);
      end
      2'b01: begin
        disp_plain    = FIELD_LEN_W'(1);
        disp_with_sib = FIELD_LEN_W'(1);
      end
      2'b10: begin
        disp_plain    = FIELD_LEN_W'(4);
        disp_with_sib = FIELD_LEN_W'(4);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/ifp_lane_accum.sv
module ifp_lane_accum #(
  parameter  int LANES  = 4,
  parameter  int LANE_W = 8,
  localparam int IDX_W  = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clear,
  input  logic                    wr_en,
  input  logic [IDX_W-1:0]        wr_idx,
  input  logic [LANE_W-1:0]       wr_data,
  output logic [LANES*LANE_W-1:0] value
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] lane_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              lane_q <= '0;
      else if (clear)                          lane_q <= '0;
      else if (wr_en && wr_idx == IDX_W'(g))   lane_q <= wr_data;
    end
    assign value[g*LANE_W +: LANE_W] = lane_q;
  end
endmodule

// File: rtl/ifp_field_parser.sv
module ifp_field_parser
  import ifp_pkg::*;
#(
  parameter logic [7:0] ESC_BYTE = 8'h0F
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [BYTE_W-1:0]       in_byte,
  input  logic                    attr_has_modrm,
  input  logic [1:0]              attr_imm_sel,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic                    out_two_byte,
  output logic [BYTE_W-1:0]       out_op_first,
  output logic [BYTE_W-1:0]       out_op_second,
  output logic                    out_has_modrm,
  output logic [BYTE_W-1:0]       out_modrm,
  output logic                    out_has_sib,
  output logic [BYTE_W-1:0]       out_sib,
  output logic [FIELD_LEN_W-1:0]  out_disp_len,
  output logic [FIELD_W-1:0]      out_disp,
  output logic [FIELD_LEN_W-1:0]  out_imm_len,
  output logic [FIELD_W-1:0]      out_imm,
  output logic [RECORD_LEN_W-1:0] out_length
);
  localparam int IDX_W = (FIELD_BYTES > 1) ? $clog2(FIELD_BYTES) : 1;

  ifp_state_e               state_q, state_d;
  logic                     two_q, two_d, has_m_q, has_m_d, has_sib_q, has_sib_d;
  logic [BYTE_W-1:0]        op1_q, op1_d, op2_q, op2_d, modrm_q, modrm_d, sib_q, sib_d;
  logic [FIELD_LEN_W-1:0]   dlen_q, dlen_d, ilen_q, ilen_d, cnt_q, cnt_d;
  logic [RECORD_LEN_W-1:0]  len_q, len_d;
  logic                     take, reg_en, accum_clear;
  logic                     sib_follows;
  logic [FIELD_LEN_W-1:0]   disp_plain, disp_with_sib, attr_ilen;
  logic [BYTE_W-1:0]        dec_modrm;
  ifp_state_e               after_opcode;

  assign in_ready  = (state_q != ST_EMIT);
  assign out_valid = (state_q == ST_EMIT);
  assign take      = in_valid && in_ready;
  assign reg_en    = take || (out_valid && out_ready);
  assign dec_modrm = (state_q == ST_MODRM) ? in_byte : modrm_q;
  assign attr_ilen = imm_sel_bytes(attr_imm_sel);

  ifp_addr_decode u_dec (
    .modrm_byte    (dec_modrm),
    .sib_byte      (in_byte),
    .sib_follows   (sib_follows),
    .disp_plain    (disp_plain),
    .disp_with_sib (disp_with_sib)
  );

  ifp_lane_accum #(.LANES(FIELD_BYTES), .LANE_W(BYTE_W)) u_disp (
    .clk (clk), .rst_n (rst_n), .clear (accum_clear),
    .wr_en (take && state_q == ST_DISP), .wr_idx (cnt_q[IDX_W-1:0]),
    .wr_data (in_byte), .value (out_disp)
  );

  ifp_lane_accum #(.LANES(FIELD_BYTES), .LANE_W(BYTE_W)) u_imm (
    .clk (clk), .rst_n (rst_n), .clear (accum_clear),
    .wr_en (take && state_q == ST_IMM), .wr_idx (cnt_q[IDX_W-1:0]),
    .wr_data (in_byte), .value (out_imm)
  );

  // Where to go once the last opcode byte is taken
  always_comb begin
    if (attr_has_modrm)       after_opcode = ST_MODRM;
    else if (attr_ilen != '0) after_opcode = ST_IMM;
    else                      after_opcode = ST_EMIT;
  end

  // Next-state process
  always_comb begin
    state_d = state_q;  two_d = two_q;  has_m_d = has_m_q;  has_sib_d = has_sib_q;
    op1_d = op1_q;  op2_d = op2_q;  modrm_d = modrm_q;  sib_d = sib_q;
    dlen_d = dlen_q;  ilen_d = ilen_q;  cnt_d = cnt_q;  len_d = len_q;
    accum_clear = 1'b0;
    if (take && state_q != ST_OPCODE) len_d = len_q + RECORD_LEN_W'(1);
    case (state_q)
      ST_OPCODE: if (take) begin
        op1_d = in_byte;  op2_d = '0;  modrm_d = '0;  sib_d = '0;
        has_sib_d = 1'b0;  dlen_d = '0;  cnt_d = '0;
        len_d = RECORD_LEN_W'(1);  accum_clear = 1'b1;
        if (in_byte == ESC_BYTE) begin
          two_d = 1'b1;  has_m_d = 1'b0;  ilen_d = '0;  state_d = ST_OP2;
        end else begin
          two_d = 1'b0;  has_m_d = attr_has_modrm;  ilen_d = attr_ilen;
          state_d = after_opcode;
        end
      end
      ST_OP2: if (take) begin
        op2_d = in_byte;  has_m_d = attr_has_modrm;  ilen_d = attr_ilen;
        state_d = after_opcode;
      end
      ST_MODRM: if (take) begin
        modrm_d = in_byte;
        if (sib_follows) begin
          has_sib_d = 1'b1;  state_d = ST_SIB;
        end else begin
          dlen_d = disp_plain;
          if (disp_plain != '0)  state_d = ST_DISP;
          else if (ilen_q != '0) state_d = ST_IMM;
          else                   state_d = ST_EMIT;
        end
      end
      ST_SIB: if (take) begin
        sib_d = in_byte;  dlen_d = disp_with_sib;
        if (disp_with_sib != '0) state_d = ST_DISP;
        else if (ilen_q != '0)   state_d = ST_IMM;
        else                     state_d = ST_EMIT;
      end
      ST_DISP: if (take) begin
        if (cnt_q == dlen_q - FIELD_LEN_W'(1)) begin
          cnt_d = '0;
          state_d = (ilen_q != '0) ? ST_IMM : ST_EMIT;
        end else cnt_d = cnt_q + FIELD_LEN_W'(1);
      end
      ST_IMM: if (take) begin
        if (cnt_q == ilen_q - FIELD_LEN_W'(1)) begin
          cnt_d = '0;  state_d = ST_EMIT;
        end else cnt_d = cnt_q + FIELD_LEN_W'(1);
      end
      ST_EMIT: if (out_ready) state_d = ST_OPCODE;
      default: state_d = ST_OPCODE;
    endcase
  end

  // Register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_OPCODE;  two_q <= 1'b0;  has_m_q <= 1'b0;  has_sib_q <= 1'b0;
      op1_q <= '0;  op2_q <= '0;  modrm_q <= '0;  sib_q <= '0;
      dlen_q <= '0;  ilen_q <= '0;  cnt_q <= '0;  len_q <= '0;
    end else if (reg_en) begin
      state_q <= state_d;  two_q <= two_d;  has_m_q <= has_m_d;  has_sib_q <= has_sib_d;
      op1_q <= op1_d;  op2_q <= op2_d;  modrm_q <= modrm_d;  sib_q <= sib_d;
      dlen_q <= dlen_d;  ilen_q <= ilen_d;  cnt_q <= cnt_d;  len_q <= len_d;
    end
  end

  assign out_two_byte  = two_q;
  assign out_op_first  = op1_q;
  assign out_op_second = op2_q;
  assign out_has_modrm = has_m_q;
  assign out_modrm     = modrm_q;
  assign out_has_sib   = has_sib_q;
  assign out_sib       = sib_q;
  assign out_disp_len  = dlen_q;
  assign out_imm_len   = ilen_q;
  assign out_length    = len_q;

  // R9: no input accepted while a record waits
  a_r9_ready_low_pending: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);
  // R9: a waiting record holds steady
  a_r9_record_held: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_length)
      && $stable(out_disp) && $stable(out_imm) && $stable(out_op_first));
  // R9: back to opcode intake the cycle after the record is taken
  a_r9_return_to_opcode: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready |=> !out_valid && in_ready);
  // R8: byte counter agrees with the field flags and sizes
  a_r8_length_sum: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_length == RECORD_LEN_W'(1) + RECORD_LEN_W'(out_two_byte)
      + RECORD_LEN_W'(out_has_modrm) + RECORD_LEN_W'(out_has_sib)
      + RECORD_LEN_W'(out_disp_len) + RECORD_LEN_W'(out_imm_len));
  // R4: scale-index-base presence rule on the emitted record
  a_r4_sib_rule: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_has_sib == (out_has_modrm && out_modrm[7:6] != 2'b11
      && out_modrm[2:0] == 3'b100));
  // R2: one-byte opcodes leave the second opcode byte clear
  a_r2_second_clear: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_two_byte |-> out_op_second == '0);
  // R5: no addressing byte means no displacement
  a_r5_no_disp_without_modrm: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_has_modrm |-> out_disp_len == '0 && !out_has_sib);
endmodule

// File: tb/ifp_field_parser_bench.sv
`timescale 1ns/1ps
module ifp_field_parser_bench;
  logic        clk = 1'b0;
  logic        rst_n, in_valid, in_ready, attr_has_modrm, out_valid, out_ready;
  logic [7:0]  in_byte;
  logic [1:0]  attr_imm_sel;
  logic        out_two_byte, out_has_modrm, out_has_sib;
  logic [7:0]  out_op_first, out_op_second, out_modrm, out_sib;
  logic [2:0]  out_disp_len, out_imm_len;
  logic [31:0] out_disp, out_imm;
  logic [3:0]  out_length;

  always #2.5 clk = ~clk;

  ifp_field_parser u_ifp_field_parser (
    .clk, .rst_n, .in_valid, .in_ready, .in_byte, .attr_has_modrm, .attr_imm_sel,
    .out_valid, .out_ready, .out_two_byte, .out_op_first, .out_op_second,
    .out_has_modrm, .out_modrm, .out_has_sib, .out_sib, .out_disp_len, .out_disp,
    .out_imm_len, .out_imm, .out_length
  );

  int checks = 0, failures = 0, cyc = 0, rmode = 0;
  bit finished = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [7:0] q[$];
  bit  m_done = 0, m_has = 0;
  int  m_imm = 0;
  bit  e_two, e_hm, e_hs;
  logic [7:0] e_op1, e_op2, e_modrm, e_sib;
  int  e_dl, e_il, e_len;
  logic [31:0] e_disp, e_imm;

  function automatic int sel2bytes(input logic [1:0] s);
    return (s == 2'd3) ? 4 : int'(s);
  endfunction

  task automatic ref_walk(output int total);
    int n, idx, dl;
    logic [7:0] m, s;
    n = q.size(); total = -1;
    e_two = 0; e_hm = 0; e_hs = 0; e_op1 = 0; e_op2 = 0; e_modrm = 0; e_sib = 0;
    e_dl = 0; e_il = 0; e_len = 0; e_disp = 0; e_imm = 0;
    if (n < 1) return;
    e_op1 = q[0]; e_two = (q[0] == 8'h0F); idx = e_two ? 2 : 1;
    if (n < idx) return;
    if (e_two) e_op2 = q[1];
    e_hm = m_has; e_il = m_imm;
    if (m_has) begin
      if (n < idx + 1) return;
      m = q[idx]; e_modrm = m; idx++; dl = 0;
      if (m[7:6] != 2'b11 && m[2:0] == 3'b100) begin
        if (n < idx + 1) return;
        s = q[idx]; e_sib = s; e_hs = 1; idx++;
        if (m[7:6] == 2'b00 && s[2:0] == 3'b101) dl = 4;
      end else if (m[7:6] == 2'b00 && m[2:0] == 3'b101) dl = 4;
      if (m[7:6] == 2'b01) dl = 1;
      if (m[7:6] == 2'b10) dl = 4;
      e_dl = dl;
      for (int k = 0; k < dl; k++) if (idx + k < n) e_disp[8*k +: 8] = q[idx+k];
      idx += dl;
    end
    for (int k = 0; k < m_imm; k++) if (idx + k < n) e_imm[8*k +: 8] = q[idx+k];
    idx += m_imm;
    total = idx; e_len = idx;
  endtask

  always @(posedge clk) begin
    int t;
    if (!rst_n) begin
      q.delete(); m_done = 0;
    end else if (m_done) begin
      if (out_ready) begin m_done = 0; q.delete(); end
    end else if (in_valid) begin
      q.push_back(in_byte);
      if ((q.size() == 1 && in_byte != 8'h0F) || (q.size() == 2 && q[0] == 8'h0F)) begin
        m_has = attr_has_modrm; m_imm = sel2bytes(attr_imm_sel);
      end
      ref_walk(t);
      if (t == q.size()) m_done = 1;
    end
  end

  // ---------------- per-cycle comparison ----------------
  always @(negedge clk) begin
    int t;
    if (rst_n && !finished) begin
      chk("R9 out_valid", 32'(out_valid), 32'(m_done));
      chk("R9 in_ready", 32'(in_ready), 32'(!m_done));
      if (m_done && out_valid) begin
        ref_walk(t);
        chk("R2 two_byte", 32'(out_two_byte), 32'(e_two));
        chk("R2 op_first", 32'(out_op_first), 32'(e_op1));
        chk("R2 op_second", 32'(out_op_second), 32'(e_op2));
        chk("R3 has_modrm", 32'(out_has_modrm), 32'(e_hm));
        chk("R3 imm_len", 32'(out_imm_len), 32'(e_il));
        chk("R4 modrm", 32'(out_modrm), 32'(e_modrm));
        chk("R4 has_sib", 32'(out_has_sib), 32'(e_hs));
        chk("R4 sib", 32'(out_sib), 32'(e_sib));
        chk("R5 disp_len", 32'(out_disp_len), 32'(e_dl));
        chk("R6 disp", out_disp, e_disp);
        chk("R7 imm", out_imm, e_imm);
        chk("R8 length", 32'(out_length), 32'(e_len));
      end
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    out_ready = 1'b1;
    forever begin
      @(posedge clk); #1;
      cyc++;
      out_ready = (rmode == 0) || (cyc % 3 == 0);
    end
  end

  task automatic drive_byte(input logic [7:0] b, input bit hm, input logic [1:0] sel);
    bit acc;
    in_valid = 1'b1; in_byte = b; attr_has_modrm = hm; attr_imm_sel = sel;
    do begin
      @(negedge clk); acc = in_ready;
      @(posedge clk); #1;
    end while (!acc);
    in_valid = 1'b0;
  endtask

  task automatic send(input logic [7:0] b[$], input bit hm, input logic [1:0] sel, input int gap);
    int fin;
    fin = (b[0] == 8'h0F) ? 1 : 0;
    foreach (b[i]) begin
      if (i == fin) drive_byte(b[i], hm, sel);
      else          drive_byte(b[i], ~hm, ~sel);  // R3: ignored attributes
      repeat (gap) begin @(posedge clk); #1; end
    end
  endtask

  task automatic run_set(input int gap);
    send('{8'h90}, 0, 2'd0, gap);
    send('{8'h05, 8'h11, 8'h22, 8'h33, 8'h44}, 0, 2'd3, gap);
    send('{8'h0F, 8'hAF, 8'hC1}, 1, 2'd0, gap);
    send('{8'h89, 8'h05, 8'hA1, 8'hB2, 8'hC3, 8'hD4}, 1, 2'd0, gap);
    send('{8'h8B, 8'h44, 8'h24, 8'hF8}, 1, 2'd0, gap);
    send('{8'h83, 8'h04, 8'h25, 8'h78, 8'h56, 8'h34, 8'h12, 8'h7F}, 1, 2'd1, gap);
    send('{8'hC7, 8'h80, 8'h01, 8'h02, 8'h03, 8'h04, 8'hEE, 8'hDD, 8'hCC, 8'hBB}, 1, 2'd3, gap);
    send('{8'h0F, 8'hBA, 8'h84, 8'h8D, 8'h10, 8'h20, 8'h30, 8'h40,
           8'h55, 8'h66, 8'h77, 8'h88}, 1, 2'd3, gap);
    send('{8'h8B, 8'hE4}, 1, 2'd0, gap);
    send('{8'hC2, 8'h34, 8'h12}, 0, 2'd2, gap);
    send('{8'h8B, 8'h04, 8'h24}, 1, 2'd0, gap);
    send('{8'h0F, 8'h84, 8'h9A}, 0, 2'd1, gap);
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_byte = '0; attr_has_modrm = 1'b0; attr_imm_sel = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 out_valid after reset", 32'(out_valid), 32'd0);
    chk("R1 in_ready after reset", 32'(in_ready), 32'd1);
    @(posedge clk); #1;
    run_set(0);
    rmode = 1;
    run_set(1);
    // R10: reset part-way through an instruction
    drive_byte(8'hC7, 1, 2'd3);
    drive_byte(8'h80, 0, 2'd0);
    drive_byte(8'h01, 0, 2'd0);
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R10 out_valid after mid reset", 32'(out_valid), 32'd0);
    chk("R10 in_ready after mid reset", 32'(in_ready), 32'd1);
    @(posedge clk); #1;
    rmode = 0;
    send('{8'h05, 8'hEF, 8'hBE, 8'hAD, 8'hDE}, 0, 2'd3, 0);  // R10: fresh parse
    repeat (20) @(posedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #500000;
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule